// File: doc/BRIEF.md
# Two-Level Interrupt Gating Controller

This block collects level-sensitive interrupt lines and presents one interrupt request line to each of a small number of processors. Every line passes through two gates before it can reach a processor. The first is a global enable shared by all processors. The second is a mask bit held separately for each processor. Lines above the per-processor range also need a per-line routing register, which names the processors allowed to receive them. Software changes the enable and mask bits by writing an interrupt number to a set register or a clear register, so it never has to read, modify and write a bit vector.

Lines 0 to 28 are per-processor sources. Each processor has its own copy of these lines as an input, and the routing register is ignored for them. Lines from 29 upward are shared: one input per line, delivered only to the processors it is routed to. A 32-bit register bus has two windows. The global window holds the control register, the enable set/clear registers and the routing registers. The per-processor window holds the mask set/clear registers and the acknowledge register, and a processor-id input selects which processor's bank is accessed. Reading the acknowledge register returns the lowest-numbered line that is eligible for that processor, or 1023 when no line is eligible. The read has no side effect, because sources stay asserted until the device releases them.

Top module: `dual_gate_intc`

## Requirements
- R1: After reset every global enable is 0, every per-processor mask bit is 1 (masked) and every routing register is 0. With all lines high, every `irq_o` bit stays 0 and every acknowledge read returns 1023.
- R2: A read of global offset 0x000 returns the number of implemented lines in bits [11:2], with all other bits 0.
- R3: Writing line number n to global offset 0x030 sets the global enable of line n, and writing n to offset 0x034 clears it. A number at or above the line count changes no line, including a line whose number equals its low bits.
- R4: Writing n to per-processor offset 0x048 masks line n for the processor on `bus_cpu`, and writing n to offset 0x04C unmasks it. The mask bits of other processors do not change. A number at or above the line count is ignored.
- R5: The routing register of line n is at global offset 0x100 + 4*n. Bit c of it enables processor c. Only the low NUM_CPU bits are stored, and a read returns those bits with zeros above them.
- R6: A line n in 0..28 is eligible for processor c when input bit `pcpu_lvl_i[c*29+n]` is high, its global enable is 1 and processor c's mask bit for n is 0. Its routing register has no effect.
- R7: A line n of 29 or above is eligible for processor c when `shr_lvl_i[n-29]` is high, its global enable is 1, processor c's mask bit is 0 and bit c of its routing register is 1.
- R8: A read of per-processor offset 0x044 returns in bits [9:0] the lowest-numbered line eligible for the selected processor, or 1023 if none is eligible, with bits [31:10] zero. The read does not change any pending state.
- R9: `irq_o[c]` is 1 exactly when at least one line is eligible for processor c.
- R10: Read data and `bus_rvalid` appear on the clock edge that follows the edge sampling `bus_rd`, and `bus_rvalid` is 1 only then. An input level change or register write becomes visible on `irq_o` at the second rising edge after it is applied. An acknowledge read issued on the cycle after a write already reflects that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_pcpu | input | 1 | 1 selects the per-processor window, 0 the global window |
| bus_cpu | input | CPUW | Processor id that selects the per-processor bank |
| bus_addr | input | 12 | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pcpu_lvl_i | input | NUM_CPU*(PCPU_LAST+1) | Per-processor source levels, bit c*(PCPU_LAST+1)+n |
| shr_lvl_i | input | NUM_IRQ-PCPU_LAST-1 | Shared source levels, bit n-(PCPU_LAST+1) |
| irq_o | output | NUM_CPU | Registered interrupt request per processor |

## Verification
Source levels are registered once on entry, and the request outputs are registered from the eligibility logic. A level change or register write applied on a falling edge is therefore due on `irq_o` after the second rising edge. The bench waits two full cycles before comparing `irq_o`, and one directed case checks that the output still holds its old value after the first edge. An acknowledge read is registered on the edge that samples the strobe, so the bench samples `bus_rdata` and `bus_rvalid` on the falling edge that follows. Every expected value comes from a model in the bench that tracks enables, masks, routes and levels.

// File: rtl/dgi_pkg.sv
package dgi_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 10;

  // global window
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_GEN_SET = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_GEN_CLR = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_ROUTE   = 12'h100;
  // per-processor window
  localparam logic [ADDR_W-1:0] OFS_ACK     = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_MSK_SET = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_MSK_CLR = 12'h04C;

  localparam logic [ID_W-1:0] NONE_ID = 10'h3FF;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_GEN_SET,
    OP_GEN_CLR,
    OP_MSK_SET,
    OP_MSK_CLR,
    OP_ROUTE
  } wr_op_e;

endpackage

// File: rtl/dgi_regs.sv
module dgi_regs
  import dgi_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 48,
  parameter int CPUW    = 1,
  parameter int IW      = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic                       pcpu,
  input  logic [CPUW-1:0]            cpu,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_IRQ-1:0]         gen_en,
  output logic [NUM_CPU*NUM_IRQ-1:0] mask_flat,
  output logic [NUM_IRQ*NUM_CPU-1:0] route_flat,
  output logic                       rt_hit,
  output logic [NUM_CPU-1:0]         rt_rd
);

  wr_op_e            op;
  logic              num_ok;
  logic [IW-1:0]     num_idx;
  logic [ADDR_W-1:0] rt_off;
  logic [IW-1:0]     rt_idx;

  assign num_ok  = (wdata < DATA_W'(NUM_IRQ));
  assign num_idx = wdata[IW-1:0];

  assign rt_off = addr - OFS_ROUTE;
  assign rt_idx = rt_off[IW+1:2];
  assign rt_hit = (addr >= OFS_ROUTE) && (addr[1:0] == 2'b00) &&
                  (32'(rt_off[ADDR_W-1:2]) < NUM_IRQ);

  always_comb begin
    op = OP_NONE;
    if (wr) begin
      if (!pcpu) begin
        if (addr == OFS_GEN_SET)      op = OP_GEN_SET;
        else if (addr == OFS_GEN_CLR) op = OP_GEN_CLR;
        else if (rt_hit)              op = OP_ROUTE;
      end else begin
        if (addr == OFS_MSK_SET)      op = OP_MSK_SET;
        else if (addr == OFS_MSK_CLR) op = OP_MSK_CLR;
      end
    end
  end

  // global enables
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en <= '0;
    end else if (num_ok) begin
      if (op == OP_GEN_SET)      gen_en[num_idx] <= 1'b1;
      else if (op == OP_GEN_CLR) gen_en[num_idx] <= 1'b0;
    end
  end

  // one mask bank per processor
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic [NUM_IRQ-1:0] bank_q;
    logic               sel;

    assign sel = num_ok && (cpu == CPUW'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q <= '1;
      end else if (sel) begin
        if (op == OP_MSK_SET)      bank_q[num_idx] <= 1'b1;
        else if (op == OP_MSK_CLR) bank_q[num_idx] <= 1'b0;
      end
    end

    assign mask_flat[c*NUM_IRQ +: NUM_IRQ] = bank_q;
  end

  // one routing register per line
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_route
    logic [NUM_CPU-1:0] rq;

    always_ff @(posedge clk) begin
      if (rst)                                    rq <= '0;
      else if (op == OP_ROUTE && rt_idx == IW'(n)) rq <= wdata[NUM_CPU-1:0];
    end

    assign route_flat[n*NUM_CPU +: NUM_CPU] = rq;
  end

  always_comb begin
    rt_rd = '0;
    for (int n = 0; n < NUM_IRQ; n++) begin
      if (rt_idx == IW'(n)) rt_rd = route_flat[n*NUM_CPU +: NUM_CPU];
    end
  end

endmodule

// File: rtl/dgi_gate.sv
module dgi_gate #(
  parameter int NUM_CPU   = 2,
  parameter int NUM_IRQ   = 48,
  parameter int PCPU_LAST = 28
) (
  input  logic [NUM_CPU*(PCPU_LAST+1)-1:0]   pcpu_lvl,
  input  logic [NUM_IRQ-PCPU_LAST-2:0]       shr_lvl,
  input  logic [NUM_IRQ-1:0]                 gen_en,
  input  logic [NUM_CPU*NUM_IRQ-1:0]         mask_flat,
  input  logic [NUM_IRQ*NUM_CPU-1:0]         route_flat,
  output logic [NUM_CPU*NUM_IRQ-1:0]         elig
);

  localparam int NPC = PCPU_LAST + 1;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
      logic open;
      assign open = gen_en[n] & ~mask_flat[c*NUM_IRQ+n];
      if (n < NPC) begin : g_private
        assign elig[c*NUM_IRQ+n] = open & pcpu_lvl[c*NPC+n];
      end else begin : g_shared
        assign elig[c*NUM_IRQ+n] = open & shr_lvl[n-NPC] & route_flat[n*NUM_CPU+c];
      end
    end
  end

endmodule

// File: rtl/dgi_pick.sv
module dgi_pick
  import dgi_pkg::*;
#(
  parameter int N = 48
) (
  input  logic [N-1:0]    vec,
  output logic            hit,
  output logic [ID_W-1:0] id
);

  assign hit = |vec;

  always_comb begin
    id = NONE_ID;
    for (int n = N - 1; n >= 0; n--) begin
      if (vec[n]) id = ID_W'(n);
    end
  end

endmodule

// File: rtl/dual_gate_intc.sv
module dual_gate_intc
  import dgi_pkg::*;
#(
  parameter int NUM_CPU   = 2,
  parameter int NUM_IRQ   = 48,
  parameter int PCPU_LAST = 28,
  parameter int CPUW      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic                              bus_pcpu,
  input  logic [CPUW-1:0]                   bus_cpu,
  input  logic [11:0]                       bus_addr,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  output logic                              bus_rvalid,
  input  logic [NUM_CPU*(PCPU_LAST+1)-1:0]  pcpu_lvl_i,
  input  logic [NUM_IRQ-PCPU_LAST-2:0]      shr_lvl_i,
  output logic [NUM_CPU-1:0]                irq_o
);

  localparam int IW = $clog2(NUM_IRQ);

  logic [NUM_CPU*(PCPU_LAST+1)-1:0] pcpu_q;
  logic [NUM_IRQ-PCPU_LAST-2:0]     shr_q;
  logic [NUM_IRQ-1:0]               gen_en;
  logic [NUM_CPU*NUM_IRQ-1:0]       mask_flat;
  logic [NUM_IRQ*NUM_CPU-1:0]       route_flat;
  logic [NUM_CPU*NUM_IRQ-1:0]       elig;
  logic                             rt_hit;
  logic [NUM_CPU-1:0]               rt_rd;
  logic [ID_W-1:0]                  ack_id [NUM_CPU];
  logic [NUM_CPU-1:0]               any_hit;
  logic [DATA_W-1:0]                rd_mux;

  // source levels registered once on entry
  always_ff @(posedge clk) begin
    if (rst) begin
      pcpu_q <= '0;
      shr_q  <= '0;
    end else begin
      pcpu_q <= pcpu_lvl_i;
      shr_q  <= shr_lvl_i;
    end
  end

  dgi_regs #(
    .NUM_CPU (NUM_CPU),
    .NUM_IRQ (NUM_IRQ),
    .CPUW    (CPUW),
    .IW      (IW)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr         (bus_wr),
    .pcpu       (bus_pcpu),
    .cpu        (bus_cpu),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .gen_en     (gen_en),
    .mask_flat  (mask_flat),
    .route_flat (route_flat),
    .rt_hit     (rt_hit),
    .rt_rd      (rt_rd)
  );

  dgi_gate #(
    .NUM_CPU   (NUM_CPU),
    .NUM_IRQ   (NUM_IRQ),
    .PCPU_LAST (PCPU_LAST)
  ) u_gate (
    .pcpu_lvl   (pcpu_q),
    .shr_lvl    (shr_q),
    .gen_en     (gen_en),
    .mask_flat  (mask_flat),
    .route_flat (route_flat),
    .elig       (elig)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_pick
    dgi_pick #(.N(NUM_IRQ)) u_pick (
      .vec (elig[c*NUM_IRQ +: NUM_IRQ]),
      .hit (any_hit[c]),
      .id  (ack_id[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= any_hit;
  end

  always_comb begin
    rd_mux = '0;
    if (!bus_pcpu) begin
      if (bus_addr == OFS_CTRL) rd_mux = {20'b0, ID_W'(NUM_IRQ), 2'b00};
      else if (rt_hit)          rd_mux = DATA_W'(rt_rd);
    end else if (bus_addr == OFS_ACK) begin
      rd_mux = {22'b0, ack_id[bus_cpu]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/dgi_chk.sv
module dgi_chk
  import dgi_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 48,
  parameter int CPUW    = 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_rd,
  input logic                       bus_pcpu,
  input logic [CPUW-1:0]            bus_cpu,
  input logic [11:0]                bus_addr,
  input logic [31:0]                bus_rdata,
  input logic                       bus_rvalid,
  input logic [NUM_CPU-1:0]         irq_o,
  input logic [NUM_IRQ-1:0]         gen_en,
  input logic [NUM_CPU*NUM_IRQ-1:0] mask_flat
);

  logic ack_rd;
  assign ack_rd = bus_rd && bus_pcpu && (bus_addr == OFS_ACK);

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R10

  AST_RVALID_ONLY_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid); // R10

  AST_CTRL_COUNT: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_pcpu && bus_addr == OFS_CTRL) |=>
      (bus_rdata == {20'b0, ID_W'(NUM_IRQ), 2'b00})); // R2

  AST_ACK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> (bus_rdata[9:0] == NONE_ID ||
                32'(bus_rdata[9:0]) < NUM_IRQ) && bus_rdata[31:10] == '0); // R8

  AST_NO_ENABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (gen_en == '0) |=> (irq_o == '0)); // R3

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    AST_ACK_MATCHES_IRQ: assert property (@(posedge clk) disable iff (rst)
      (ack_rd && bus_cpu == CPUW'(c)) |=>
        ((bus_rdata[9:0] == NONE_ID) == !irq_o[c])); // R9

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
      (&mask_flat[c*NUM_IRQ +: NUM_IRQ]) |=> !irq_o[c]); // R4
  end

endmodule

bind dual_gate_intc dgi_chk #(
  .NUM_CPU (NUM_CPU),
  .NUM_IRQ (NUM_IRQ),
  .CPUW    (CPUW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_pcpu   (bus_pcpu),
  .bus_cpu    (bus_cpu),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .irq_o      (irq_o),
  .gen_en     (gen_en),
  .mask_flat  (mask_flat)
);

// File: tb/sim_dual_gate_intc.sv
module sim_dual_gate_intc;

  localparam int CLK_PERIOD = 10;
  localparam int NC   = 2;
  localparam int NI   = 48;
  localparam int PL   = 28;
  localparam int NPL  = PL + 1;
  localparam int NS   = NI - NPL;
  localparam int CPUW = 1;
  localparam int NONE = 1023;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic              bus_pcpu = 1'b0;
  logic [CPUW-1:0]   bus_cpu = '0;
  logic [11:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [NC*NPL-1:0] pcpu_lvl = '0;
  logic [NS-1:0]     shr_lvl = '0;
  logic [NC-1:0]     irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model
  bit       gen_m [NI];
  bit       msk_m [NC][NI];
  bit [3:0] rt_m  [NI];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_gate_intc #(.NUM_CPU(NC), .NUM_IRQ(NI), .PCPU_LAST(PL)) u0 (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_pcpu   (bus_pcpu),
    .bus_cpu    (bus_cpu),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pcpu_lvl_i (pcpu_lvl),
    .shr_lvl_i  (shr_lvl),
    .irq_o      (irq_o)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit elig(input int c, input int n);
    if (!gen_m[n] || msk_m[c][n]) return 1'b0;
    if (n < NPL) return pcpu_lvl[c*NPL+n];
    return shr_lvl[n-NPL] && rt_m[n][c];
  endfunction

  function automatic int exp_ack(input int c);
    for (int n = 0; n < NI; n++) if (elig(c, n)) return n;
    return NONE;
  endfunction

  task automatic wr(input bit pc, input int cpu, input int addr, input int data);
    bus_wr = 1'b1; bus_pcpu = pc; bus_cpu = CPUW'(cpu);
    bus_addr = 12'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input bit pc, input int cpu, input int addr,
                    output logic [31:0] d, output bit v);
    bus_rd = 1'b1; bus_pcpu = pc; bus_cpu = CPUW'(cpu); bus_addr = 12'(addr);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    v = bus_rvalid;
  endtask

  task automatic gen_set(input int n);
    wr(0, 0, 'h30, n);
    if (n < NI) gen_m[n] = 1'b1;
  endtask

  task automatic gen_clr(input int n);
    wr(0, 0, 'h34, n);
    if (n < NI) gen_m[n] = 1'b0;
  endtask

  task automatic msk_set(input int c, input int n);
    wr(1, c, 'h48, n);
    if (n < NI) msk_m[c][n] = 1'b1;
  endtask

  task automatic msk_clr(input int c, input int n);
    wr(1, c, 'h4C, n);
    if (n < NI) msk_m[c][n] = 1'b0;
  endtask

  task automatic route_wr(input int n, input int v);
    wr(0, 0, 'h100 + 4*n, v);
    if (n < NI) rt_m[n] = 4'(v & ((1 << NC) - 1));
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ack_chk(input string tag, input int c, input int exp);
    logic [31:0] d;
    bit v;
    rd(1, c, 'h44, d, v);
    check({tag, " ack"}, longint'(d), longint'(exp));
    check("R10 rvalid", longint'(v), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit v;
    void'($urandom(32'd4711));
    for (int n = 0; n < NI; n++) begin
      gen_m[n] = 0; rt_m[n] = 0;
      for (int c = 0; c < NC; c++) msk_m[c][n] = 1;
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, all lines high
    pcpu_lvl = '1; shr_lvl = '1;
    settle();
    check("R1 irq_o", longint'(irq_o), 0);
    ack_chk("R1 cpu0", 0, NONE);
    ack_chk("R1 cpu1", 1, NONE);
    rd(0, 0, 'h100 + 4*40, d, v);
    check("R1 route", longint'(d), 0);
    pcpu_lvl = '0; shr_lvl = '0;
    settle();

    // R2: control register
    rd(0, 0, 'h000, d, v);
    check("R2 ctrl", longint'(d), longint'(NI << 2));

    // R5: routing storage
    route_wr(40, 'hFF);
    rd(0, 0, 'h100 + 4*40, d, v);
    check("R5 route trunc", longint'(d), 3);
    route_wr(40, 2);
    rd(0, 0, 'h100 + 4*40, d, v);
    check("R5 route", longint'(d), 2);

    // R3: enable set with out-of-range number aliasing line 5
    msk_clr(0, 5);
    pcpu_lvl[0*NPL+5] = 1'b1;
    gen_set(64 + 5);
    settle();
    ack_chk("R3 alias ignored", 0, NONE);
    check("R3 irq0 off", longint'(irq_o[0]), 0);
    gen_set(5);
    settle();
    ack_chk("R3 enabled", 0, 5);
    check("R3 irq0 on", longint'(irq_o[0]), 1);

    // R4: per-processor masks are independent
    pcpu_lvl[1*NPL+5] = 1'b1;
    settle();
    ack_chk("R4 cpu1 masked", 1, NONE);
    msk_clr(1, 5);
    settle();
    ack_chk("R4 cpu1 open", 1, 5);
    msk_set(1, 5);
    settle();
    ack_chk("R4 cpu1 remasked", 1, NONE);
    ack_chk("R4 cpu0 untouched", 0, 5);

    // R6: routing ignored for per-processor lines; own level used
    route_wr(5, 2);
    settle();
    ack_chk("R6 route ignored", 0, 5);
    msk_clr(1, 5);
    pcpu_lvl[0*NPL+5] = 1'b0;
    settle();
    ack_chk("R6 cpu0 level low", 0, NONE);
    ack_chk("R6 cpu1 own level", 1, 5);
    pcpu_lvl[1*NPL+5] = 1'b0;

    // R7: shared line follows routing
    gen_set(40); msk_clr(0, 40); msk_clr(1, 40);
    shr_lvl[40-NPL] = 1'b1;
    settle();
    ack_chk("R7 routed cpu1", 1, 40);
    ack_chk("R7 not routed cpu0", 0, NONE);
    route_wr(40, 1);
    settle();
    ack_chk("R7 routed cpu0", 0, 40);
    ack_chk("R7 not routed cpu1", 1, NONE);
    gen_clr(40);
    settle();
    ack_chk("R3 cleared", 0, NONE);

    // R8: lowest number wins, read does not clear
    gen_set(40); route_wr(40, 3);
    gen_set(33); msk_clr(0, 33); msk_clr(1, 33); route_wr(33, 3);
    shr_lvl[33-NPL] = 1'b1;
    settle();
    ack_chk("R8 lowest", 0, 33);
    ack_chk("R8 no clear", 0, 33);
    ack_chk("R8 cpu1 lowest", 1, 33);
    shr_lvl[33-NPL] = 1'b0;
    settle();
    ack_chk("R8 next", 0, 40);

    // R10 / R9: output latency of two rising edges
    shr_lvl[40-NPL] = 1'b0;
    settle();
    check("R9 idle", longint'(irq_o[0]), 0);
    shr_lvl[33-NPL] = 1'b1;
    @(negedge clk);
    check("R10 one edge", longint'(irq_o[0]), 0);
    @(negedge clk);
    check("R10 two edges", longint'(irq_o[0]), 1);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 8);
      int n  = int'($urandom % (NI + 16));
      int c  = int'($urandom % NC);
      case (op)
        0, 1: gen_set(n);
        2:    gen_clr(n);
        3:    msk_set(c, n);
        4, 5: msk_clr(c, n);
        6:    route_wr(n, int'($urandom % 16));
        default: begin
          if ($urandom % 2 == 0) begin
            int b = int'($urandom % (NC*NPL));
            pcpu_lvl[b] = ~pcpu_lvl[b];
          end else begin
            int b = int'($urandom % NS);
            shr_lvl[b] = ~shr_lvl[b];
          end
        end
      endcase
      settle();
      for (int k = 0; k < NC; k++) begin
        check("R9 random irq", longint'(irq_o[k]), longint'(exp_ack(k) != NONE));
        ack_chk("R8 random", k, exp_ack(k));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule